// File: doc/BRIEF.md
# Endian-Aware Byte-Lane Access Unit

This unit connects a 32-bit load/store datapath to a data memory that is 32 bits wide and addressed by byte. For each request it takes a byte address, an access size, a write flag, write data, a signed-load flag and a byte-order select. It also takes the word that memory returns for that address. From these it produces four things: the physical word index, a per-lane byte-enable mask with a write strobe, write data already placed in the byte lanes, and a load result that is right-justified and extended.

Requests that are misaligned, and requests with a reserved size code, are refused. The unit raises an error flag, drives every byte enable and the write strobe low, and returns zero as the load result. It never splits an access over two memory words.

The unit is combinational, with an optional output register selected by a parameter. A two-flop synchronizer releases the reset of that register.

Top module: `byte_lane_unit`

## Requirements
- R1: `word_idx` equals the byte address with its two lowest bits dropped. The byte address is `word_idx*4` plus the lane offset `addr[1:0]`.
- R2: Size code 2'b00 is a byte, 2'b01 a half-word and 2'b10 a word. Code 2'b11 is reserved and always raises `align_err`.
- R3: A request is accepted only when the address modulo the access length in bytes is zero. Otherwise `align_err` is 1, `byte_en` is 4'b0000, `mem_we` is 0 and `rd_data` is 0, for loads and stores alike.
- R4: With `big_endian`=0, the byte at offset o of a word sits in lane o, which is bits 8o+7:8o. `byte_en` bit i is set exactly for the lanes that hold the bytes of an accepted access.
- R5: With `big_endian`=1, the byte at offset o sits in lane 3-o. The mapping is mirrored, with `byte_en` set the same way.
- R6: Load results are right-justified. In little-endian mode the byte at the lowest address is the least significant byte of the item. In big-endian mode the byte at the lowest address is the most significant byte.
- R7: For byte and half-word loads, the bits above the item copy its top bit when `signed_ld`=1, and are zero when `signed_ld`=0.
- R8: `lane_wdata` holds `wdata[7:0]` in all four lanes for a byte, `wdata[15:0]` in both halves for a half-word, and `wdata` unchanged for a word. Writing the enabled lanes into memory stores the item's bytes in the order of R4/R5.
- R9: With `OUT_REG`=1, every output reflects the inputs of the previous rising clock edge. While reset is held, all outputs are zero.
- R10: `mem_we` is 1 exactly when `we`=1 and the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address of the request |
| size | input | 2 | Access size code |
| we | input | 1 | Request is a store |
| big_endian | input | 1 | Byte-order select, 1 = big-endian |
| signed_ld | input | 1 | Sign-extend narrow loads |
| wdata | input | 32 | Store data, right-justified |
| mem_rdata | input | 32 | Word read from memory at the request's word |
| word_idx | output | ADDR_W-2 | Physical word index |
| byte_en | output | 4 | Lane enables of the access |
| lane_wdata | output | 32 | Store data placed in the byte lanes |
| mem_we | output | 1 | Write strobe for accepted stores |
| rd_data | output | 32 | Right-justified, extended load result |
| align_err | output | 1 | Misaligned or reserved-size request |

## Verification
With the default `OUT_REG`=1, every result appears after exactly one rising edge. This holds for the index, the enables, the steered data, the load result and the error flag.

The bench drives each request on a falling edge, lets one rising edge pass, and checks on the next falling edge. The sweep covers every combination of byte order, size code, lane offset, signed flag and write flag, over several data patterns. The bench compares the outputs against a four-byte array reference.

One extra check samples the outputs just after a new request is driven, before the next rising edge. It confirms they still show the previous request, which checks the single-cycle latency.

// File: rtl/blu_pkg.sv
package blu_pkg;
  localparam int LANE_W     = 8;
  localparam int WORD_BYTES = 4;
  localparam int DATA_W     = LANE_W * WORD_BYTES;
  localparam int OFS_W      = $clog2(WORD_BYTES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  function automatic int size_bytes(acc_size_e s);
    case (s)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      SZ_WORD: return WORD_BYTES;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/blu_rst_sync.sv
module blu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_q_n <= meta_q;
    end
  end
endmodule

// File: rtl/blu_align_chk.sv
module blu_align_chk
  import blu_pkg::*;
(
  input  logic [OFS_W-1:0] ofs,
  input  acc_size_e        size,
  output logic             err
);
  // Legal when the low offset bits below the access length are all zero.
  always_comb begin
    case (size)
      SZ_BYTE: err = 1'b0;
      SZ_HALF: err = ofs[0];
      SZ_WORD: err = |ofs;
      default: err = 1'b1;
    endcase
  end
endmodule

// File: rtl/blu_lane_map.sv
module blu_lane_map
  import blu_pkg::*;
(
  input  logic [OFS_W-1:0]      ofs,
  input  acc_size_e             size,
  input  logic                  big_endian,
  input  logic                  err,
  output logic [OFS_W-1:0]      lo_lane,
  output logic [WORD_BYTES-1:0] byte_en
);
  int nbytes;

  // Lowest lane touched by the access; the big-endian case mirrors offsets.
  always_comb begin
    nbytes = size_bytes(size);
    case (size)
      SZ_BYTE: lo_lane = big_endian ? ~ofs : ofs;
      SZ_HALF: lo_lane = big_endian ? {~ofs[1], 1'b0} : {ofs[1], 1'b0};
      default: lo_lane = '0;
    endcase
  end

  for (genvar i = 0; i < WORD_BYTES; i++) begin : g_lane
    assign byte_en[i] = !err && (i >= int'(lo_lane)) && (i < int'(lo_lane) + nbytes);
  end
endmodule

// File: rtl/blu_store_steer.sv
module blu_store_steer
  import blu_pkg::*;
(
  input  logic [DATA_W-1:0] wdata,
  input  acc_size_e         size,
  output logic [DATA_W-1:0] lane_wdata
);
  // Replication places the item in every lane it could occupy, so the
  // byte order only has to be applied through the lane enables.
  for (genvar i = 0; i < WORD_BYTES; i++) begin : g_lane
    always_comb begin
      case (size)
        SZ_BYTE: lane_wdata[i*LANE_W +: LANE_W] = wdata[0 +: LANE_W];
        SZ_HALF: lane_wdata[i*LANE_W +: LANE_W] = wdata[(i % 2)*LANE_W +: LANE_W];
        default: lane_wdata[i*LANE_W +: LANE_W] = wdata[i*LANE_W +: LANE_W];
      endcase
    end
  end
endmodule

// File: rtl/blu_load_extract.sv
module blu_load_extract
  import blu_pkg::*;
(
  input  logic [DATA_W-1:0] rdata,
  input  logic [OFS_W-1:0]  lo_lane,
  input  acc_size_e         size,
  input  logic              signed_ld,
  input  logic              err,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] shifted;

  always_comb begin
    shifted = rdata >> {lo_lane, 3'b000};
    if (err) begin
      rd_data = '0;
    end else begin
      case (size)
        SZ_BYTE: rd_data = {{(DATA_W-LANE_W){signed_ld & shifted[LANE_W-1]}},
                            shifted[LANE_W-1:0]};
        SZ_HALF: rd_data = {{(DATA_W-2*LANE_W){signed_ld & shifted[2*LANE_W-1]}},
                            shifted[2*LANE_W-1:0]};
        default: rd_data = shifted;
      endcase
    end
  end
endmodule

// File: rtl/byte_lane_unit.sv
module byte_lane_unit
  import blu_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [1:0]            size,
  input  logic                  we,
  input  logic                  big_endian,
  input  logic                  signed_ld,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic [ADDR_W-OFS_W-1:0] word_idx,
  output logic [WORD_BYTES-1:0] byte_en,
  output logic [DATA_W-1:0]     lane_wdata,
  output logic                  mem_we,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  align_err
);
  localparam int IDX_W = ADDR_W - OFS_W;

  typedef struct packed {
    logic [IDX_W-1:0]      idx;
    logic [WORD_BYTES-1:0] be;
    logic [DATA_W-1:0]     wd;
    logic                  we;
    logic [DATA_W-1:0]     rd;
    logic                  err;
  } resp_t;

  acc_size_e        size_e;
  logic [OFS_W-1:0] ofs;
  logic [OFS_W-1:0] lo_lane;
  logic             err_c;
  logic [WORD_BYTES-1:0] be_c;
  logic [DATA_W-1:0] wd_c;
  logic [DATA_W-1:0] rd_c;
  logic             rst_q_n;
  resp_t            resp_nxt;
  resp_t            resp_out;

  assign size_e = acc_size_e'(size);
  assign ofs    = addr[OFS_W-1:0];

  blu_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  blu_align_chk u_align (
    .ofs  (ofs),
    .size (size_e),
    .err  (err_c)
  );

  blu_lane_map u_map (
    .ofs        (ofs),
    .size       (size_e),
    .big_endian (big_endian),
    .err        (err_c),
    .lo_lane    (lo_lane),
    .byte_en    (be_c)
  );

  blu_store_steer u_steer (
    .wdata      (wdata),
    .size       (size_e),
    .lane_wdata (wd_c)
  );

  blu_load_extract u_extract (
    .rdata     (mem_rdata),
    .lo_lane   (lo_lane),
    .size      (size_e),
    .signed_ld (signed_ld),
    .err       (err_c),
    .rd_data   (rd_c)
  );

  always_comb begin
    resp_nxt.idx = addr[ADDR_W-1:OFS_W];
    resp_nxt.be  = be_c;
    resp_nxt.wd  = wd_c;
    resp_nxt.we  = we & ~err_c;
    resp_nxt.rd  = rd_c;
    resp_nxt.err = err_c;
  end

  if (OUT_REG) begin : g_out_reg
    resp_t resp_q;
    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n) resp_q <= '0;
      else          resp_q <= resp_nxt;
    end
    assign resp_out = resp_q;
  end else begin : g_out_comb
    assign resp_out = resp_nxt;
  end

  assign word_idx   = resp_out.idx;
  assign byte_en    = resp_out.be;
  assign lane_wdata = resp_out.wd;
  assign mem_we     = resp_out.we;
  assign rd_data    = resp_out.rd;
  assign align_err  = resp_out.err;
endmodule

// File: rtl/blu_chk.sv
module blu_chk
  import blu_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter bit OUT_REG = 1'b1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [ADDR_W-1:0]     addr,
  input logic [1:0]            size,
  input logic                  we,
  input logic                  signed_ld,
  input logic [DATA_W-1:0]     wdata,
  input logic [ADDR_W-OFS_W-1:0] word_idx,
  input logic [WORD_BYTES-1:0] byte_en,
  input logic [DATA_W-1:0]     lane_wdata,
  input logic                  mem_we,
  input logic [DATA_W-1:0]     rd_data,
  input logic                  align_err
);
  logic [ADDR_W-1:0] addr_d;
  logic [1:0]        size_d;
  logic              we_d;
  logic              sg_d;
  logic [DATA_W-1:0] wdata_d;
  logic              live_q;

  if (OUT_REG) begin : g_dly
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_d <= '0; size_d <= '0; we_d <= 1'b0; sg_d <= 1'b0; wdata_d <= '0;
      end else begin
        addr_d <= addr; size_d <= size; we_d <= we; sg_d <= signed_ld; wdata_d <= wdata;
      end
    end
  end else begin : g_nodly
    assign addr_d = addr; assign size_d = size; assign we_d = we;
    assign sg_d = signed_ld; assign wdata_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  p_widx_r1: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> word_idx == addr_d[ADDR_W-1:OFS_W]);

  p_rsvd_size_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && size_d == 2'b11) |-> align_err);

  p_err_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && align_err) |-> (byte_en == '0 && !mem_we && rd_data == '0));

  p_lane_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !align_err) |-> $countones(byte_en) == (size_d == 2'b00 ? 1 : (size_d == 2'b01 ? 2 : 4)));

  p_zext_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !align_err && size_d == 2'b00 && !sg_d) |-> rd_data[DATA_W-1:LANE_W] == '0);

  p_byte_rep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !align_err && size_d == 2'b00) |-> lane_wdata == {WORD_BYTES{wdata_d[LANE_W-1:0]}});

  p_wstrobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> mem_we == (we_d && !align_err));
endmodule

bind byte_lane_unit blu_chk #(.ADDR_W(ADDR_W), .OUT_REG(OUT_REG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .addr       (addr),
  .size       (size),
  .we         (we),
  .signed_ld  (signed_ld),
  .wdata      (wdata),
  .word_idx   (word_idx),
  .byte_en    (byte_en),
  .lane_wdata (lane_wdata),
  .mem_we     (mem_we),
  .rd_data    (rd_data),
  .align_err  (align_err)
);

// File: tb/tb_byte_lane_unit.sv
module tb_byte_lane_unit;
  localparam int ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] addr;
  logic [1:0]        size;
  logic              we, big_endian, signed_ld;
  logic [31:0]       wdata, mem_rdata;
  logic [ADDR_W-3:0] word_idx;
  logic [3:0]        byte_en;
  logic [31:0]       lane_wdata, rd_data;
  logic              mem_we, align_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  byte_lane_unit #(.ADDR_W(ADDR_W), .OUT_REG(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .size(size), .we(we),
    .big_endian(big_endian), .signed_ld(signed_ld), .wdata(wdata),
    .mem_rdata(mem_rdata), .word_idx(word_idx), .byte_en(byte_en),
    .lane_wdata(lane_wdata), .mem_we(mem_we), .rd_data(rd_data),
    .align_err(align_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] pats [3];
    pats[0] = 32'h80FF7F01;
    pats[1] = 32'h12A4C65E;
    pats[2] = 32'hF00D8B37;
    rst_n = 1'b0;
    addr = 12'hABC; size = 2'b10; we = 1'b1; big_endian = 1'b0;
    signed_ld = 1'b1; wdata = 32'hFFFFFFFF; mem_rdata = 32'hFFFFFFFF;
    repeat (3) @(negedge clk);
    // R9: outputs held at zero while reset is asserted
    check("R9 reset", {word_idx, byte_en, mem_we, align_err}, '0);
    check("R9 reset", rd_data | lane_wdata, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int p = 0; p < 3; p++)
    for (int e = 0; e < 2; e++)
    for (int sz = 0; sz < 4; sz++)
    for (int o = 0; o < 4; o++)
    for (int sg = 0; sg < 2; sg++)
    for (int wr = 0; wr < 2; wr++) begin
      logic [7:0]  m [4];
      logic [31:0] ev, ebe, act_st, exp_st;
      logic [ADDR_W-1:0] a;
      int n;
      bit legal;
      for (int k = 0; k < 4; k++) m[k] = pats[p][8*k +: 8] ^ 8'(o * 37);
      a = ADDR_W'((p * 301 + sz * 53 + e * 17) * 4 + o);
      n = (sz == 3) ? 0 : (1 << sz);
      legal = (sz < 3) && (o % n == 0);
      addr = a; size = 2'(sz); we = wr[0]; big_endian = e[0]; signed_ld = sg[0];
      wdata = pats[(p + 1) % 3] ^ 32'(o * 1234567);
      for (int k = 0; k < 4; k++)
        mem_rdata[8 * (e ? 3 - k : k) +: 8] = m[k];
      ev = 0; ebe = 0; act_st = 0; exp_st = 0;
      if (legal) begin
        for (int k = 0; k < n; k++) begin
          ev  |= 32'(m[o + k]) << (8 * (e ? n - 1 - k : k));
          ebe |= 32'(1) << (e ? 3 - (o + k) : o + k);
        end
        if (sg != 0 && n < 4 && ev[8 * n - 1]) ev |= ~((32'(1) << (8 * n)) - 1);
      end
      @(negedge clk);
      check("R1 word index", 32'(word_idx), 32'(a >> 2));
      check("R2/R3 error flag", 32'(align_err), 32'(!legal));
      check(e ? "R5 big-endian lanes" : "R4 little-endian lanes", 32'(byte_en), ebe);
      check(e ? "R6/R7 big-endian load" : "R6/R7 little-endian load", rd_data, ev);
      check("R10 write strobe", 32'(mem_we), 32'(wr != 0 && legal));
      if (legal) begin
        // R8: apply enabled lanes to a byte array, compare with the item bytes
        for (int k = 0; k < n; k++) begin
          int lane;
          lane = e ? 3 - (o + k) : o + k;
          if (byte_en[lane]) act_st[8 * k +: 8] = lane_wdata[8 * lane +: 8];
          exp_st[8 * k +: 8] = wdata[8 * (e ? n - 1 - k : k) +: 8];
        end
        check("R8 stored bytes", act_st, exp_st);
        if (sz == 1) check("R8 half replication", lane_wdata, {2{wdata[15:0]}});
      end
    end

    // R9: one-cycle latency, old result visible until the next rising edge
    addr = 12'h004; size = 2'b00; we = 1'b0; big_endian = 1'b0;
    @(negedge clk);
    addr = 12'h7F8;
    #1;
    check("R9 latency hold", 32'(word_idx), 32'h001);
    @(negedge clk);
    check("R9 latency update", 32'(word_idx), 32'(12'h7F8 >> 2));

    finish_run();
  end
endmodule